// File: doc/BRIEF.md
# Pipeline Flush and Exception Redirect Controller

This block steers the front of a five-stage in-order pipeline that fetches down the sequential path by default (predict not taken). When the decode stage resolves a branch as taken, the single wrong-path instruction sitting in fetch is squashed and fetch is redirected to the branch target. When the execute stage reports an arithmetic overflow, the offending instruction and the two younger ones behind it are squashed together. Fetch then jumps to a fixed handler vector, and the address of the offending instruction is latched along with a cause code. Older instructions, which are already past execute, finish normally. The result is a precise exception.

The flush and select outputs are combinational from the current-cycle events, so they act on the pipeline registers at the next clock edge. Three slot registers stand in for the fetch/decode instruction word and for the control bundles of the decode/execute and execute/memory boundaries. A flushed slot loads all zeros. An all-zero instruction word decodes as a shift of register 0, which is a no-op, and an all-zero control bundle writes nothing.

A four-state machine tracks which pipeline slots hold squashed work. It masks events that could only come from those squashed slots:

- ST_RUN accepts both a taken branch and an overflow.
- ST_BR_SHADOW is the cycle after an accepted branch. It ignores branch events and still accepts overflow.
- ST_XC_SHADOW1 is the first cycle after an accepted overflow. It ignores both kinds of event.
- ST_XC_SHADOW2 is the second cycle after an accepted overflow. It ignores overflow and accepts branches.

The transitions are the same from every state:

- An accepted overflow goes to ST_XC_SHADOW1.
- Otherwise, an accepted branch goes to ST_BR_SHADOW.
- Otherwise, ST_XC_SHADOW1 goes to ST_XC_SHADOW2.
- Every other case returns to ST_RUN.

Top module: `flush_redirect_ctrl`

## Requirements
- R1: After reset the machine is in ST_RUN. The slot registers, the saved PC and the cause are zero. With no events present, no flush is raised and pc_sel is 0.
- R2: A taken branch accepted with no accepted overflow raises flush_if only, sets pc_sel to 1 (branch) and drives next_pc with br_target.
- R3: An accepted overflow raises flush_if, flush_id and flush_ex together, sets pc_sel to 2 (vector) and drives next_pc with the handler vector, 0x40000040 by default.
- R4: When an overflow and a taken branch are both accepted in one cycle, the overflow decides every output, exactly as in R3.
- R5: At the edge closing a cycle with an accepted overflow, saved_pc loads ex_pc and cause loads 1 (the overflow code; 0 means none). Both hold their values in all other cycles.
- R6: At each edge a slot register loads all zeros if its flush was high, and its input otherwise. The slots and their flushes are: ifid_word with flush_if, idex_ctrl with flush_id, exmem_ctrl with flush_ex.
- R7: In the cycle after an accepted branch, br_taken is ignored (no flush, no redirect), and ovf_ex is still accepted.
- R8: In the two cycles after an accepted overflow, ovf_ex is ignored. br_taken is ignored in the first of those cycles and accepted in the second.
- R9: With no accepted event, no flush is raised, pc_sel is 0 (sequential) and next_pc equals seq_pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_taken | input | 1 | Branch in decode resolved as taken |
| br_target | input | 32 | Target address of that branch |
| ovf_ex | input | 1 | Overflow flagged by the instruction in execute |
| ex_pc | input | 32 | PC of the instruction in execute |
| seq_pc | input | 32 | Sequential next fetch address |
| fetch_word | input | 32 | Instruction word leaving fetch |
| id_ctrl | input | 8 | Control bundle leaving decode |
| ex_ctrl | input | 8 | Control bundle leaving execute |
| flush_if | output | 1 | Squash the fetch slot |
| flush_id | output | 1 | Squash the decode slot |
| flush_ex | output | 1 | Squash the execute slot |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 vector |
| next_pc | output | 32 | Selected next fetch address |
| saved_pc | output | 32 | PC of the last instruction that overflowed |
| cause | output | 4 | Exception cause code |
| ifid_word | output | 32 | Modelled fetch/decode instruction slot |
| idex_ctrl | output | 8 | Modelled decode/execute control slot |
| exmem_ctrl | output | 8 | Modelled execute/memory control slot |

## Verification
A wrong machine state appears at the ports in the same cycle, as a flush or redirect that should have been masked, or one that is missing. The bench therefore compares flush_if, flush_id, flush_ex, pc_sel and next_pc every cycle against an arithmetic model of the masking rules. It sweeps every three-cycle history of the two event inputs, which reaches each state under each event pair, and then runs a long pseudo-random stream. A bad capture or a bad slot update appears one edge later in saved_pc, cause or the slot outputs, and those are checked at the following falling edge.

// File: rtl/flush_redirect_pkg.sv
package flush_redirect_pkg;
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_BR_SHADOW  = 2'd1,
        ST_XC_SHADOW1 = 2'd2,
        ST_XC_SHADOW2 = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_VECTOR = 2'd2
    } pc_sel_e;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF  = 4'd1;
endpackage

// File: rtl/flush_fsm.sv
module flush_fsm
    import flush_redirect_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    br_taken,
    input  logic    ovf_ex,
    output logic    flush_if,
    output logic    flush_id,
    output logic    flush_ex,
    output pc_sel_e pc_sel
);
    ctl_state_e state_q, state_d;
    logic br_ok, ovf_ok, take_br, take_ovf;

    // which events can come from live slots in this state
    always_comb begin
        br_ok  = 1'b1;
        ovf_ok = 1'b1;
        unique case (state_q)
            ST_RUN:        begin end
            ST_BR_SHADOW:  br_ok = 1'b0;
            ST_XC_SHADOW1: begin br_ok = 1'b0; ovf_ok = 1'b0; end
            ST_XC_SHADOW2: ovf_ok = 1'b0;
        endcase
    end

    assign take_ovf = ovf_ex && ovf_ok;
    assign take_br  = br_taken && br_ok;

    always_comb begin
        if (take_ovf)                     state_d = ST_XC_SHADOW1;
        else if (take_br)                 state_d = ST_BR_SHADOW;
        else if (state_q == ST_XC_SHADOW1) state_d = ST_XC_SHADOW2;
        else                              state_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // exception outranks branch
    always_comb begin
        flush_if = 1'b0;
        flush_id = 1'b0;
        flush_ex = 1'b0;
        pc_sel   = SEL_SEQ;
        if (take_ovf) begin
            flush_if = 1'b1;
            flush_id = 1'b1;
            flush_ex = 1'b1;
            pc_sel   = SEL_VECTOR;
        end else if (take_br) begin
            flush_if = 1'b1;
            pc_sel   = SEL_BRANCH;
        end
    end

    a_r3_ovf_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ex && (state_q == ST_RUN || state_q == ST_BR_SHADOW))
        |-> (flush_if && flush_id && flush_ex && pc_sel == SEL_VECTOR));

    a_r2_branch_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !ovf_ex && state_q == ST_RUN)
        |-> (flush_if && !flush_id && !flush_ex && pc_sel == SEL_BRANCH));

    a_r8_ovf_shadow_first: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ex |=> (!flush_ex && !flush_if));

    a_r8_ovf_shadow_second: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ex |-> ##2 !flush_ex);

    a_r7_branch_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_if && !flush_ex) |=> (!flush_if || flush_ex));
endmodule

// File: rtl/xc_capture.sv
module xc_capture
    import flush_redirect_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [ADDR_W-1:0]  pc_in,
    output logic [ADDR_W-1:0]  epc,
    output logic [CAUSE_W-1:0] cause
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= CAUSE_NONE;
        end else if (take) begin
            epc   <= pc_in;
            cause <= CAUSE_OVF;
        end
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (epc == $past(pc_in) && cause == CAUSE_OVF));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(epc) && $stable(cause)));
endmodule

// File: rtl/slot_reg.sv
module slot_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (flush) q <= '0;
        else            q <= d;
    end

    a_r6_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q == '0));

    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (q == $past(d)));
endmodule

// File: rtl/flush_redirect_ctrl.sv
module flush_redirect_ctrl
    import flush_redirect_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              INSTR_W     = 32,
    parameter int              CTRL_W      = 8,
    parameter logic [ADDR_W-1:0] VECTOR_ADDR = 32'h4000_0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               br_taken,
    input  logic [ADDR_W-1:0]  br_target,
    input  logic               ovf_ex,
    input  logic [ADDR_W-1:0]  ex_pc,
    input  logic [ADDR_W-1:0]  seq_pc,
    input  logic [INSTR_W-1:0] fetch_word,
    input  logic [CTRL_W-1:0]  id_ctrl,
    input  logic [CTRL_W-1:0]  ex_ctrl,
    output logic               flush_if,
    output logic               flush_id,
    output logic               flush_ex,
    output logic [1:0]         pc_sel,
    output logic [ADDR_W-1:0]  next_pc,
    output logic [ADDR_W-1:0]  saved_pc,
    output logic [CAUSE_W-1:0] cause,
    output logic [INSTR_W-1:0] ifid_word,
    output logic [CTRL_W-1:0]  idex_ctrl,
    output logic [CTRL_W-1:0]  exmem_ctrl
);
    pc_sel_e sel;

    flush_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_taken (br_taken),
        .ovf_ex   (ovf_ex),
        .flush_if (flush_if),
        .flush_id (flush_id),
        .flush_ex (flush_ex),
        .pc_sel   (sel)
    );

    assign pc_sel = sel;

    always_comb begin
        case (sel)
            SEL_BRANCH: next_pc = br_target;
            SEL_VECTOR: next_pc = VECTOR_ADDR;
            default:    next_pc = seq_pc;
        endcase
    end

    xc_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (flush_ex),
        .pc_in (ex_pc),
        .epc   (saved_pc),
        .cause (cause)
    );

    slot_reg #(.W(INSTR_W)) u_ifid (
        .clk(clk), .rst_n(rst_n), .flush(flush_if), .d(fetch_word), .q(ifid_word)
    );
    slot_reg #(.W(CTRL_W)) u_idex (
        .clk(clk), .rst_n(rst_n), .flush(flush_id), .d(id_ctrl), .q(idex_ctrl)
    );
    slot_reg #(.W(CTRL_W)) u_exmem (
        .clk(clk), .rst_n(rst_n), .flush(flush_ex), .d(ex_ctrl), .q(exmem_ctrl)
    );

    a_r4_ovf_over_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ex && br_taken) |-> (next_pc == VECTOR_ADDR));
endmodule

// File: tb/test_flush_redirect_ctrl.sv
module test_flush_redirect_ctrl;
    localparam int CLK_P = 10;
    localparam logic [31:0] VEC = 32'h4000_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_taken = 1'b0, ovf_ex = 1'b0;
    logic [31:0] br_target = '0, ex_pc = '0, seq_pc = '0, fetch_word = '0;
    logic [7:0]  id_ctrl = '0, ex_ctrl = '0;
    logic        flush_if, flush_id, flush_ex;
    logic [1:0]  pc_sel;
    logic [31:0] next_pc, saved_pc, ifid_word;
    logic [3:0]  cause;
    logic [7:0]  idex_ctrl, exmem_ctrl;

    int total = 0;
    int bad = 0;
    int ms = 0;
    logic [31:0] rng = 32'h1234_5678;
    logic [31:0] e_epc = '0, e_ifid = '0;
    logic [3:0]  e_cause = '0;
    logic [7:0]  e_idex = '0, e_exmem = '0;

    always #(CLK_P/2) clk = ~clk;

    flush_redirect_ctrl i_flush_redirect_ctrl (
        .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_target(br_target),
        .ovf_ex(ovf_ex), .ex_pc(ex_pc), .seq_pc(seq_pc), .fetch_word(fetch_word),
        .id_ctrl(id_ctrl), .ex_ctrl(ex_ctrl), .flush_if(flush_if), .flush_id(flush_id),
        .flush_ex(flush_ex), .pc_sel(pc_sel), .next_pc(next_pc), .saved_pc(saved_pc),
        .cause(cause), .ifid_word(ifid_word), .idex_ctrl(idex_ctrl), .exmem_ctrl(exmem_ctrl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x;
        x = v ^ (v << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check_regs();
        chk("R5 saved_pc", saved_pc, e_epc);
        chk("R5 cause", {28'd0, cause}, {28'd0, e_cause});
        chk("R6 ifid_word", ifid_word, e_ifid);
        chk("R6 idex_ctrl", {24'd0, idex_ctrl}, {24'd0, e_idex});
        chk("R6 exmem_ctrl", {24'd0, exmem_ctrl}, {24'd0, e_exmem});
    endtask

    // one cycle: called just after a falling edge
    task automatic step(input logic b, input logic o);
        logic acc_b, acc_o, f_if, f_idex;
        logic [1:0] sel;
        logic [31:0] npc;
        string tag;
        check_regs();
        rng = nxt(rng); br_target = rng;
        rng = nxt(rng); ex_pc = rng;
        rng = nxt(rng); seq_pc = rng;
        rng = nxt(rng); fetch_word = rng;
        rng = nxt(rng); id_ctrl = rng[7:0]; ex_ctrl = rng[15:8];
        br_taken = b; ovf_ex = o;
        #1;
        acc_o = o && (ms == 0 || ms == 1);
        acc_b = b && (ms == 0 || ms == 3);
        f_if = acc_o || acc_b;
        f_idex = acc_o;
        sel = acc_o ? 2'd2 : (acc_b ? 2'd1 : 2'd0);
        npc = acc_o ? VEC : (acc_b ? br_target : seq_pc);
        if (acc_o && b)            tag = "R4";
        else if (acc_o)            tag = "R3";
        else if (acc_b)            tag = "R2";
        else if (ms == 1 && b)     tag = "R7";
        else if (ms >= 2 && (b || o)) tag = "R8";
        else                       tag = "R9";
        chk({tag, " flush_if"}, {31'd0, flush_if}, {31'd0, f_if});
        chk({tag, " flush_id"}, {31'd0, flush_id}, {31'd0, f_idex});
        chk({tag, " flush_ex"}, {31'd0, flush_ex}, {31'd0, f_idex});
        chk({tag, " pc_sel"}, {30'd0, pc_sel}, {30'd0, sel});
        chk({tag, " next_pc"}, next_pc, npc);
        if (acc_o) begin e_epc = ex_pc; e_cause = 4'd1; end
        e_ifid  = f_if ? 32'd0 : fetch_word;
        e_idex  = f_idex ? 8'd0 : id_ctrl;
        e_exmem = f_idex ? 8'd0 : ex_ctrl;
        ms = acc_o ? 2 : (acc_b ? 1 : (ms == 2 ? 3 : 0));
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_regs();
        chk("R1 flush_if", {31'd0, flush_if}, 32'd0);
        chk("R1 flush_ex", {31'd0, flush_ex}, 32'd0);
        chk("R1 pc_sel", {30'd0, pc_sel}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // sweep every three-cycle event history, then let it settle
        for (int h = 0; h < 64; h++) begin
            step(h[0], h[1]);
            step(h[2], h[3]);
            step(h[4], h[5]);
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
        end
        // pseudo-random event stream
        for (int k = 0; k < 2000; k++) begin
            rng = nxt(rng);
            step(rng[3:0] < 4'd5, rng[7:4] < 4'd4);
        end
        step(1'b0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule